// File: doc/BRIEF.md
# Translation Fault Exception State Unit

This unit keeps the processor state that changes when an address translation fault is taken, and restores the mode state when the handler returns. On a fault strobe it does several things in the same cycle:

- It pushes a three-level stack of kernel/user and interrupt-enable bit pairs. The new current pair puts the core in kernel mode with interrupts off.
- It saves the restart address. This is the faulting instruction, or the preceding branch when the faulting instruction sat in a delay slot.
- It records a fault code and keeps the offending virtual address.
- For translation faults, it builds a page-table pointer and loads the page number field used for the next mapping write. The pointer is a software-written base followed by the faulting page number without its top bit, then two zero bits.

A return strobe pops the mode stack. Software can write the mode stack, the page-table base and the page number field through a simple write port. A one-bit vector select tells the fetch logic whether the last fault goes to the dedicated refill handler or to the general handler. Two nested faults need no software save, because the stack is three levels deep.

Top module: `trap_state_unit`

## Requirements
- R1: While rstN is low, and after reset, every output is zero: mode stack 0 (kernel, interrupts off at every level), restart address, cause, bad address, context, page number field and vector select.
- R2: On faultStb, statusOut becomes {statusOut[3:0], 2'b00}. The layout is bit0 current IE, bit1 current KU, bits 3:2 previous pair, bits 5:4 old pair, and KU=1 means user.
- R3: On rfeStb without faultStb, statusOut becomes {statusOut[5:4], statusOut[5:2]}. If both strobes are high in the same cycle, only the fault push happens.
- R4: On faultStb, epcOut takes branchPc when inDelaySlot is 1 and faultPc otherwise. Without faultStb, epcOut holds.
- R5: On faultStb with faultKind 0 to 6, badVaddrOut takes faultVaddr. Kind 7 leaves it unchanged.
- R6: contextOut is {base[31:21], vpn[20:2], 2'b00}. For faultKind 0 to 4, bits 20:2 take faultVaddr[30:12] while the base bits keep their value. Kinds 5 to 7 leave contextOut unchanged.
- R7: For faultKind 0 to 4, entryHiVpnOut takes faultVaddr[31:12].
- R8: causeOut holds a 5-bit code at bits 6:2, and every other bit is 0. The codes are: kind 0 modified → 1, kind 1 miss on load → 2, kind 2 miss on store → 3, kind 3 refill on load → 2, kind 4 refill on store → 3, kind 5 address error on load → 4, kind 6 address error on store → 5, kind 7 other → 0.
- R9: On faultStb, vecSelOut becomes 1 for kinds 3 and 4 (refill vector) and 0 for all other kinds.
- R10: When swWrEn is high and no fault is taken, the write takes effect by select value:
  - swWrSel 0 writes statusOut from swWrData[5:0], unless rfeStb is also high.
  - swWrSel 1 writes the context base from swWrData[31:21].
  - swWrSel 2 writes entryHiVpnOut from swWrData[31:12].
  - swWrSel 3 changes nothing.
  - A fault in the same cycle cancels the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous active-low reset |
| faultStb | input | 1 | take a fault this cycle |
| faultKind | input | 3 | fault type, encoded as in R8 |
| faultVaddr | input | 32 | faulting virtual address |
| faultPc | input | 32 | address of faulting instruction |
| inDelaySlot | input | 1 | faulting instruction is in a branch delay slot |
| branchPc | input | 32 | address of the branch before the slot |
| rfeStb | input | 1 | return from exception, pops the mode stack |
| swWrEn | input | 1 | software register write enable |
| swWrSel | input | 2 | software write target |
| swWrData | input | 32 | software write data |
| statusOut | output | 6 | mode and interrupt-enable stack |
| epcOut | output | 32 | restart address |
| causeOut | output | 32 | fault code register |
| badVaddrOut | output | 32 | last faulting virtual address |
| contextOut | output | 32 | page-table pointer |
| entryHiVpnOut | output | 20 | page number field for mapping writes |
| vecSelOut | output | 1 | 1 selects the refill handler vector |

## Verification
The assertions assume that faultStb, rfeStb and swWrEn are full-cycle pulses sampled at the rising edge, and that faultKind and the address inputs are valid whenever faultStb is high. Each checking property expects its update on the next edge. The stimulus changes every input only on the falling edge and returns each strobe low after one cycle. Deliberate collisions (a fault with a return, a fault with a write, a return with a status write) are driven as single cycles, so they exercise the stated priorities rather than undefined overlap.

// File: rtl/trap_state_pkg.sv
package trap_state_pkg;

  typedef enum logic [2:0] {
    FK_MOD       = 3'd0,
    FK_MISS_LD   = 3'd1,
    FK_MISS_ST   = 3'd2,
    FK_REFILL_LD = 3'd3,
    FK_REFILL_ST = 3'd4,
    FK_ADDR_LD   = 3'd5,
    FK_ADDR_ST   = 3'd6,
    FK_OTHER     = 3'd7
  } faultKind_e;

  localparam int CODE_W = 5;
  localparam int STK_W  = 6;

  localparam logic [1:0] SEL_STATUS  = 2'd0;
  localparam logic [1:0] SEL_CONTEXT = 2'd1;
  localparam logic [1:0] SEL_ENTRYHI = 2'd2;

  typedef struct packed {
    logic              takeFault;
    logic              refill;
    logic              xlate;
    logic              loadBad;
    logic [CODE_W-1:0] code;
    logic              popStack;
    logic              wrStatus;
    logic              wrContext;
    logic              wrEntryHi;
  } trapCtl_t;

endpackage

// File: rtl/trap_state_ctrl.sv
module trap_state_ctrl
  import trap_state_pkg::*;
(
  input  logic       faultStb,
  input  logic [2:0] faultKind,
  input  logic       rfeStb,
  input  logic       swWrEn,
  input  logic [1:0] swWrSel,
  output trapCtl_t   ctl
);

  always_comb begin
    ctl = '0;
    ctl.takeFault = faultStb;
    case (faultKind_e'(faultKind))
      FK_MOD:       begin ctl.code = 5'd1; ctl.xlate = 1'b1; ctl.loadBad = 1'b1; end
      FK_MISS_LD:   begin ctl.code = 5'd2; ctl.xlate = 1'b1; ctl.loadBad = 1'b1; end
      FK_MISS_ST:   begin ctl.code = 5'd3; ctl.xlate = 1'b1; ctl.loadBad = 1'b1; end
      FK_REFILL_LD: begin ctl.code = 5'd2; ctl.xlate = 1'b1; ctl.loadBad = 1'b1; ctl.refill = 1'b1; end
      FK_REFILL_ST: begin ctl.code = 5'd3; ctl.xlate = 1'b1; ctl.loadBad = 1'b1; ctl.refill = 1'b1; end
      FK_ADDR_LD:   begin ctl.code = 5'd4; ctl.loadBad = 1'b1; end
      FK_ADDR_ST:   begin ctl.code = 5'd5; ctl.loadBad = 1'b1; end
      default:      begin ctl.code = 5'd0; end
    endcase
    // R3 / R10: fault beats return, return beats a status write
    ctl.popStack  = rfeStb && !faultStb;
    ctl.wrStatus  = swWrEn && !faultStb && !rfeStb && (swWrSel == SEL_STATUS);
    ctl.wrContext = swWrEn && !faultStb && (swWrSel == SEL_CONTEXT);
    ctl.wrEntryHi = swWrEn && !faultStb && (swWrSel == SEL_ENTRYHI);
  end

endmodule

// File: rtl/trap_state_dp.sv
module trap_state_dp
  import trap_state_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  trapCtl_t                 ctl,
  input  logic [ADDR_W-1:0]        faultVaddr,
  input  logic [ADDR_W-1:0]        faultPc,
  input  logic                     inDelaySlot,
  input  logic [ADDR_W-1:0]        branchPc,
  input  logic [ADDR_W-1:0]        swWrData,
  output logic [STK_W-1:0]         statusOut,
  output logic [ADDR_W-1:0]        epcOut,
  output logic [ADDR_W-1:0]        causeOut,
  output logic [ADDR_W-1:0]        badVaddrOut,
  output logic [ADDR_W-1:0]        contextOut,
  output logic [ADDR_W-OFFS_W-1:0] entryHiVpnOut,
  output logic                     vecSelOut
);

  localparam int VPN_W      = ADDR_W - OFFS_W;
  localparam int CTX_VPN_W  = VPN_W - 1;
  localparam int CTX_BASE_W = ADDR_W - CTX_VPN_W - 2;

  logic [STK_W-1:0]      statusQ;
  logic [ADDR_W-1:0]     epcQ;
  logic [CODE_W-1:0]     codeQ;
  logic [ADDR_W-1:0]     badQ;
  logic [CTX_BASE_W-1:0] ctxBaseQ;
  logic [CTX_VPN_W-1:0]  ctxVpnQ;
  logic [VPN_W-1:0]      hiVpnQ;
  logic                  vecQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ  <= '0;
      epcQ     <= '0;
      codeQ    <= '0;
      badQ     <= '0;
      ctxBaseQ <= '0;
      ctxVpnQ  <= '0;
      hiVpnQ   <= '0;
      vecQ     <= 1'b0;
    end else begin
      if (ctl.takeFault) begin
        statusQ <= {statusQ[STK_W-3:0], 2'b00};
        epcQ    <= inDelaySlot ? branchPc : faultPc;
        codeQ   <= ctl.code;
        vecQ    <= ctl.refill;
        if (ctl.loadBad) badQ <= faultVaddr;
        if (ctl.xlate) begin
          ctxVpnQ <= faultVaddr[ADDR_W-2:OFFS_W];
          hiVpnQ  <= faultVaddr[ADDR_W-1:OFFS_W];
        end
      end else if (ctl.popStack) begin
        statusQ <= {statusQ[STK_W-1:STK_W-2], statusQ[STK_W-1:2]};
      end else if (ctl.wrStatus) begin
        statusQ <= swWrData[STK_W-1:0];
      end
      if (ctl.wrContext) ctxBaseQ <= swWrData[ADDR_W-1 -: CTX_BASE_W];
      if (ctl.wrEntryHi) hiVpnQ   <= swWrData[ADDR_W-1:OFFS_W];
    end
  end

  assign statusOut     = statusQ;
  assign epcOut        = epcQ;
  assign causeOut      = {{(ADDR_W-CODE_W-2){1'b0}}, codeQ, 2'b00};
  assign badVaddrOut   = badQ;
  assign contextOut    = {ctxBaseQ, ctxVpnQ, 2'b00};
  assign entryHiVpnOut = hiVpnQ;
  assign vecSelOut     = vecQ;

endmodule

// File: rtl/trap_state_unit.sv
module trap_state_unit
  import trap_state_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     faultStb,
  input  logic [2:0]               faultKind,
  input  logic [ADDR_W-1:0]        faultVaddr,
  input  logic [ADDR_W-1:0]        faultPc,
  input  logic                     inDelaySlot,
  input  logic [ADDR_W-1:0]        branchPc,
  input  logic                     rfeStb,
  input  logic                     swWrEn,
  input  logic [1:0]               swWrSel,
  input  logic [ADDR_W-1:0]        swWrData,
  output logic [STK_W-1:0]         statusOut,
  output logic [ADDR_W-1:0]        epcOut,
  output logic [ADDR_W-1:0]        causeOut,
  output logic [ADDR_W-1:0]        badVaddrOut,
  output logic [ADDR_W-1:0]        contextOut,
  output logic [ADDR_W-OFFS_W-1:0] entryHiVpnOut,
  output logic                     vecSelOut
);

  trapCtl_t ctl;

  trap_state_ctrl u_ctrl (
    .faultStb (faultStb),
    .faultKind(faultKind),
    .rfeStb   (rfeStb),
    .swWrEn   (swWrEn),
    .swWrSel  (swWrSel),
    .ctl      (ctl)
  );

  trap_state_dp #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .faultVaddr   (faultVaddr),
    .faultPc      (faultPc),
    .inDelaySlot  (inDelaySlot),
    .branchPc     (branchPc),
    .swWrData     (swWrData),
    .statusOut    (statusOut),
    .epcOut       (epcOut),
    .causeOut     (causeOut),
    .badVaddrOut  (badVaddrOut),
    .contextOut   (contextOut),
    .entryHiVpnOut(entryHiVpnOut),
    .vecSelOut    (vecSelOut)
  );

endmodule

// File: rtl/trap_state_checker.sv
module trap_state_checker #(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 12
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     faultStb,
  input logic [2:0]               faultKind,
  input logic [ADDR_W-1:0]        faultVaddr,
  input logic [ADDR_W-1:0]        faultPc,
  input logic                     inDelaySlot,
  input logic [ADDR_W-1:0]        branchPc,
  input logic                     rfeStb,
  input logic                     swWrEn,
  input logic [1:0]               swWrSel,
  input logic [ADDR_W-1:0]        swWrData,
  input logic [5:0]               statusOut,
  input logic [ADDR_W-1:0]        epcOut,
  input logic [ADDR_W-1:0]        causeOut,
  input logic [ADDR_W-1:0]        badVaddrOut,
  input logic [ADDR_W-1:0]        contextOut,
  input logic [ADDR_W-OFFS_W-1:0] entryHiVpnOut,
  input logic                     vecSelOut
);

  localparam int CTX_BASE_W = OFFS_W - 1;

  a_r2_fault_push: assert property (@(posedge clk) disable iff (!rstN)
    faultStb |=> statusOut == {$past(statusOut[3:0]), 2'b00});

  a_r3_rfe_pop: assert property (@(posedge clk) disable iff (!rstN)
    (rfeStb && !faultStb) |=> statusOut == {$past(statusOut[5:4]), $past(statusOut[5:2])});

  a_r4_epc_pick: assert property (@(posedge clk) disable iff (!rstN)
    faultStb |=> epcOut == ($past(inDelaySlot) ? $past(branchPc) : $past(faultPc)));

  a_r4_epc_hold: assert property (@(posedge clk) disable iff (!rstN)
    !faultStb |=> $stable(epcOut));

  a_r5_bad_addr: assert property (@(posedge clk) disable iff (!rstN)
    (faultStb && faultKind != 3'd7) |=> badVaddrOut == $past(faultVaddr));

  a_r6_ctx_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    contextOut[1:0] == 2'b00);

  a_r6_ctx_base_kept: assert property (@(posedge clk) disable iff (!rstN)
    faultStb |=> contextOut[ADDR_W-1 -: CTX_BASE_W] == $past(contextOut[ADDR_W-1 -: CTX_BASE_W]));

  a_r7_hi_vpn: assert property (@(posedge clk) disable iff (!rstN)
    (faultStb && faultKind <= 3'd4) |=> entryHiVpnOut == $past(faultVaddr[ADDR_W-1:OFFS_W]));

  a_r8_cause_shape: assert property (@(posedge clk) disable iff (!rstN)
    (causeOut[ADDR_W-1:7] == '0) && (causeOut[1:0] == 2'b00));

  a_r9_vector: assert property (@(posedge clk) disable iff (!rstN)
    faultStb |=> vecSelOut == ($past(faultKind) == 3'd3 || $past(faultKind) == 3'd4));

  a_r10_ctx_write: assert property (@(posedge clk) disable iff (!rstN)
    (swWrEn && swWrSel == 2'd1 && !faultStb) |=>
      contextOut[ADDR_W-1 -: CTX_BASE_W] == $past(swWrData[ADDR_W-1 -: CTX_BASE_W]));

endmodule

bind trap_state_unit trap_state_checker #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_chk (
  .clk(clk), .rstN(rstN), .faultStb(faultStb), .faultKind(faultKind),
  .faultVaddr(faultVaddr), .faultPc(faultPc), .inDelaySlot(inDelaySlot),
  .branchPc(branchPc), .rfeStb(rfeStb), .swWrEn(swWrEn), .swWrSel(swWrSel),
  .swWrData(swWrData), .statusOut(statusOut), .epcOut(epcOut),
  .causeOut(causeOut), .badVaddrOut(badVaddrOut), .contextOut(contextOut),
  .entryHiVpnOut(entryHiVpnOut), .vecSelOut(vecSelOut)
);

// File: tb/trap_state_unit_test.sv
module trap_state_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        faultStb = 1'b0;
  logic [2:0]  faultKind = '0;
  logic [31:0] faultVaddr = '0;
  logic [31:0] faultPc = '0;
  logic        inDelaySlot = 1'b0;
  logic [31:0] branchPc = '0;
  logic        rfeStb = 1'b0;
  logic        swWrEn = 1'b0;
  logic [1:0]  swWrSel = '0;
  logic [31:0] swWrData = '0;
  logic [5:0]  statusOut;
  logic [31:0] epcOut, causeOut, badVaddrOut, contextOut;
  logic [19:0] entryHiVpnOut;
  logic        vecSelOut;

  int checks = 0;
  int fails  = 0;

  // expected state
  logic [5:0]  expStatus = '0;
  logic [31:0] expEpc = '0, expBad = '0;
  logic [4:0]  expCode = '0;
  logic [10:0] expBase = '0;
  logic [18:0] expCtxVpn = '0;
  logic [19:0] expHi = '0;
  logic        expVec = 1'b0;

  always #4 clk = ~clk; // 8 ns period, 125 MHz

  trap_state_unit uut (
    .clk(clk), .rstN(rstN), .faultStb(faultStb), .faultKind(faultKind),
    .faultVaddr(faultVaddr), .faultPc(faultPc), .inDelaySlot(inDelaySlot),
    .branchPc(branchPc), .rfeStb(rfeStb), .swWrEn(swWrEn), .swWrSel(swWrSel),
    .swWrData(swWrData), .statusOut(statusOut), .epcOut(epcOut),
    .causeOut(causeOut), .badVaddrOut(badVaddrOut), .contextOut(contextOut),
    .entryHiVpnOut(entryHiVpnOut), .vecSelOut(vecSelOut)
  );

  function automatic logic [4:0] codeOf(input logic [2:0] k);
    case (k)
      3'd0: return 5'd1;
      3'd1, 3'd3: return 5'd2;
      3'd2, 3'd4: return 5'd3;
      3'd5: return 5'd4;
      3'd6: return 5'd5;
      default: return 5'd0;
    endcase
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp,
                     input string req, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s (%s): got %h expected %h", req, tag, got, exp);
    end
  endtask

  task automatic checkAll(input string tag, input string stReq);
    chk({26'd0, statusOut}, {26'd0, expStatus}, stReq, tag);
    chk(epcOut, expEpc, "R4", tag);
    chk(badVaddrOut, expBad, "R5", tag);
    chk(contextOut, {expBase, expCtxVpn, 2'b00}, "R6", tag);
    chk({12'd0, entryHiVpnOut}, {12'd0, expHi}, "R7", tag);
    chk(causeOut, {25'd0, expCode, 2'b00}, "R8", tag);
    chk({31'd0, vecSelOut}, {31'd0, expVec}, "R9", tag);
  endtask

  // one cycle of stimulus, applied at a falling edge; expected state follows the requirements
  task automatic step(input logic f, input logic [2:0] k, input logic [31:0] va,
                      input logic [31:0] pc, input logic ds, input logic [31:0] bpc,
                      input logic rfe, input logic we, input logic [1:0] sel,
                      input logic [31:0] d);
    faultStb = f; faultKind = k; faultVaddr = va; faultPc = pc;
    inDelaySlot = ds; branchPc = bpc; rfeStb = rfe;
    swWrEn = we; swWrSel = sel; swWrData = d;
    if (f) begin
      expStatus = {expStatus[3:0], 2'b00};
      expEpc = ds ? bpc : pc;
      expCode = codeOf(k);
      expVec = (k == 3'd3 || k == 3'd4);
      if (k != 3'd7) expBad = va;
      if (k <= 3'd4) begin expCtxVpn = va[30:12]; expHi = va[31:12]; end
    end else begin
      if (rfe) expStatus = {expStatus[5:4], expStatus[5:2]};
      else if (we && sel == 2'd0) expStatus = d[5:0];
      if (we && sel == 2'd1) expBase = d[31:21];
      if (we && sel == 2'd2) expHi = d[31:12];
    end
    @(negedge clk);
    faultStb = 1'b0; rfeStb = 1'b0; swWrEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] addrs [4];
    addrs[0] = 32'h7fff_ffff; addrs[1] = 32'h8000_1000;
    addrs[2] = 32'hffff_f123; addrs[3] = 32'h1234_5678;

    repeat (3) @(negedge clk);
    checkAll("R1 reset held", "R1");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 after release", "R1");

    // base so context upper bits are visible (R10)
    step(0, 0, 0, 0, 0, 0, 0, 1, 2'd1, 32'hABC0_0003);
    checkAll("R10 context base write", "R10");

    // sweep every fault kind, delay slot and address pattern (R2 R4..R9)
    for (int k = 0; k < 8; k++)
      for (int ds = 0; ds < 2; ds++)
        for (int a = 0; a < 4; a++) begin
          step(1, 3'(k), addrs[a], 32'h0040_0000 + 32'(k * 16 + a * 4),
               ds[0], 32'h0050_0000 + 32'(a * 8), 0, 0, 0, 0);
          checkAll($sformatf("R2 fault kind %0d ds %0d addr %0d", k, ds, a), "R2");
        end

    // every stack value: write, pop, rewrite, push (R10 R3 R2)
    for (int s = 0; s < 64; s++) begin
      step(0, 0, 0, 0, 0, 0, 0, 1, 2'd0, 32'(s));
      checkAll($sformatf("R10 status write %0d", s), "R10");
      step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
      checkAll($sformatf("R3 pop from %0d", s), "R3");
      step(0, 0, 0, 0, 0, 0, 0, 1, 2'd0, 32'(s));
      step(1, 3'd1, 32'h0000_3000 + 32'(s << 12), 32'h100, 0, 0, 0, 0, 0, 0);
      checkAll($sformatf("R2 push from %0d", s), "R2");
    end

    // nested faults from user mode with interrupts on, then two returns (R3)
    step(0, 0, 0, 0, 0, 0, 0, 1, 2'd0, 32'h3);
    step(1, 3'd3, 32'h0040_2000, 32'h0040_0010, 0, 0, 0, 0, 0, 0);
    step(1, 3'd1, 32'hC000_4000, 32'h8000_0080, 0, 0, 0, 0, 0, 0);
    checkAll("R2 two nested faults", "R2");
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    checkAll("R3 nested returns restore user pair", "R3");

    // entryHi write, select 3 ignored (R10)
    step(0, 0, 0, 0, 0, 0, 0, 1, 2'd2, 32'h5A5A_5FFF);
    checkAll("R10 entryHi write", "R10");
    step(0, 0, 0, 0, 0, 0, 0, 1, 2'd3, 32'hFFFF_FFFF);
    checkAll("R10 select 3 ignored", "R10");

    // collisions: fault+write, fault+return, return+status write (R10 R3)
    step(1, 3'd5, 32'h9000_0001, 32'h44, 1, 32'h40, 0, 1, 2'd1, 32'h0000_0000);
    checkAll("R10 fault cancels context write", "R10");
    step(1, 3'd2, 32'h0000_7000, 32'h48, 0, 0, 1, 0, 0, 0);
    checkAll("R3 fault beats return", "R3");
    step(0, 0, 0, 0, 0, 0, 0, 1, 2'd0, 32'h2A);
    step(0, 0, 0, 0, 0, 0, 1, 1, 2'd0, 32'h01);
    checkAll("R3 return beats status write", "R3");

    // epc holds with no fault (R4)
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    checkAll("R4 idle hold", "R4");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule